// File: doc/BRIEF.md
# Word-Level Triple-Redundant Voter

This block takes three equal-width words produced by three redundant copies of a module and reduces them to one output word. Its default vote works on whole words: the first two inputs are compared, and if they match their common value is passed on. If they do not match, the third input is passed on. Because of this, the output is always one of the three input words. A per-bit majority vote can build a word that no module produced, and the word vote avoids that.

A two-bit mode input selects one of three votes. The word vote is the default. The second is a per-bit majority vote, for control bits that are independent of each other. The third is a median vote, which returns the numerically middle value of the three unsigned words and suits numeric data that may drift slightly between copies. A disagree flag reports whenever the first two inputs differ, so the surrounding system can log or diagnose a faulty copy.

The voting logic is combinational. A parameter adds an output register stage, which gives exactly one cycle of latency and keeps the flag aligned with the word.

Top module: `tmr_word_voter`

## Requirements
- R1: In word mode (mode = 2'b00), the output is input A when A equals B; otherwise it is input C.
- R2: In word mode, the output word always equals at least one of A, B or C, including when all three inputs differ.
- R3: In bitwise mode (mode = 2'b01), each output bit is set when at least two of the three corresponding input bits are set (A&B | B&C | C&A). For example, A=000, B=101, C=110 gives 100.
- R4: In median mode (mode = 2'b10), the output is the middle value of A, B and C taken as unsigned integers. When two of the inputs are equal, that repeated value is the output.
- R5: The unused mode code 2'b11 behaves exactly like word mode.
- R6: The disagree flag is high exactly when A differs from B, in every mode.
- R7: With the output register enabled (REGISTERED = 1, the default), the output word and the disagree flag show the vote of the inputs that were present at the previous rising clock edge, both on the same cycle.
- R8: While rst is high at a rising edge, the registered output word and the disagree flag are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Vote select: 00 word, 01 bitwise, 10 median, 11 word |
| in_a | input | W | Word from the first redundant copy |
| in_b | input | W | Word from the second redundant copy |
| in_c | input | W | Word from the third redundant copy |
| vote_out | output | W | Voted word |
| disagree | output | 1 | High when in_a and in_b differ |

## Verification
The case that is hardest to reach from the ports is a three-way disagreement whose per-bit majority forms a word that matches none of the inputs. Random words almost never produce this case with a telling pattern. The bench therefore drives the pattern 000/101/110 directly in every mode. Random stimulus also forces A equal to B about half of the time, because independent random words would almost never agree, and the agreeing path of the word vote would otherwise go unexercised.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

    typedef enum logic [1:0] {
        VM_WORD    = 2'b00,
        VM_BITWISE = 2'b01,
        VM_MEDIAN  = 2'b10,
        VM_SPARE   = 2'b11
    } vote_mode_e;

    // Two-of-three majority of single bits.
    function automatic logic maj_bit(input logic x, input logic y, input logic z);
        return (x & y) | (y & z) | (z & x);
    endfunction

    // The spare code falls back to the whole-word vote.
    function automatic logic uses_word_vote(input vote_mode_e m);
        return (m == VM_WORD) || (m == VM_SPARE);
    endfunction

endpackage

// File: rtl/word_selector.sv
module word_selector #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] sel,
    output logic         differ
);
    always_comb begin
        differ = (a != b);
        sel    = differ ? c : a;
    end
endmodule

// File: rtl/bit_majority.sv
module bit_majority #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] maj
);
    import tmr_vote_pkg::*;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign maj[i] = maj_bit(a[i], b[i], c[i]);
    end
endmodule

// File: rtl/median3.sv
module median3 #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    output logic [W-1:0] mid
);
    logic a_ge_b, b_ge_c, a_ge_c;

    always_comb begin
        a_ge_b = (a >= b);
        b_ge_c = (b >= c);
        a_ge_c = (a >= c);
        if (a_ge_b) begin
            if (b_ge_c)      mid = b;
            else if (a_ge_c) mid = c;
            else             mid = a;
        end else begin
            if (a_ge_c)      mid = a;
            else if (b_ge_c) mid = c;
            else             mid = b;
        end
    end
endmodule

// File: rtl/tmr_word_voter.sv
module tmr_word_voter
    import tmr_vote_pkg::*;
#(
    parameter int W          = 16,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   mode,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    output logic [W-1:0] vote_out,
    output logic         disagree
);
    vote_mode_e   mode_e;
    logic [W-1:0] word_res, maj_res, mid_res, comb_vote;
    logic         differ;

    assign mode_e = vote_mode_e'(mode);

    word_selector #(.W(W)) u_word (
        .a(in_a), .b(in_b), .c(in_c), .sel(word_res), .differ(differ)
    );

    bit_majority #(.W(W)) u_maj (
        .a(in_a), .b(in_b), .c(in_c), .maj(maj_res)
    );

    median3 #(.W(W)) u_mid (
        .a(in_a), .b(in_b), .c(in_c), .mid(mid_res)
    );

    always_comb begin
        unique case (mode_e)
            VM_BITWISE: comb_vote = maj_res;
            VM_MEDIAN:  comb_vote = mid_res;
            default:    comb_vote = word_res;
        endcase
    end

    // R2: the word vote never builds a word that no module produced
    p_word_member_r2: assert property (@(posedge clk) disable iff (rst)
        uses_word_vote(mode_e) |->
            (vote_out_next_is_member(word_res, in_a, in_b, in_c)));

    // R3: any bit where A and B agree forces the majority bit to that value
    p_bit_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (((in_a & in_b) & ~maj_res) == '0) && ((maj_res & ~(in_a | in_b)) == '0));

    // R4: the median is an input, with at most one input above and one below it
    p_median_between_r4: assert property (@(posedge clk) disable iff (rst)
        vote_out_next_is_member(mid_res, in_a, in_b, in_c) &&
        (({1'b0, in_a > mid_res} + {1'b0, in_b > mid_res} + {1'b0, in_c > mid_res}) <= 2'd1) &&
        (({1'b0, in_a < mid_res} + {1'b0, in_b < mid_res} + {1'b0, in_c < mid_res}) <= 2'd1));

    // R6: matching first and second words never raise the flag
    p_agree_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (in_a == in_b) |-> !differ);

    function automatic logic vote_out_next_is_member(
        input logic [W-1:0] v, input logic [W-1:0] x,
        input logic [W-1:0] y, input logic [W-1:0] z);
        return (v == x) || (v == y) || (v == z);
    endfunction

    if (REGISTERED) begin : g_reg
        logic [W-1:0] vote_q;
        logic         dis_q;
        logic         armed;

        always_ff @(posedge clk) begin
            if (rst) begin
                vote_q <= '0;
                dis_q  <= 1'b0;
                armed  <= 1'b0;
            end else begin
                vote_q <= comb_vote;
                dis_q  <= differ;
                armed  <= 1'b1;
            end
        end

        assign vote_out = vote_q;
        assign disagree = dis_q;

        // R7: word and flag both follow the previous edge's vote
        p_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
            armed |-> ((vote_out == $past(comb_vote)) && (disagree == $past(differ))));

        // R8: a reset edge leaves both outputs cleared
        p_reset_clear_r8: assert property (@(posedge clk)
            $past(rst) |-> ((vote_out == '0) && !disagree));
    end else begin : g_comb
        assign vote_out = comb_vote;
        assign disagree = differ;
    end
endmodule

// File: tb/tmr_word_voter_test.sv
module tmr_word_voter_test;
    localparam int W         = 16;
    localparam int CLK_NS    = 10;
    localparam int WATCHDOG  = 20000;

    typedef struct {
        logic [1:0]   mode;
        logic [W-1:0] a, b, c;
        logic [W-1:0] exp;
        logic         dis;
        string        tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] in_a = '0, in_b = '0, in_c = '0;
    logic [W-1:0] vote_out;
    logic         disagree;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    item_t q[$];

    tmr_word_voter #(.W(W), .REGISTERED(1'b1)) uut (
        .clk(clk), .rst(rst), .mode(mode), .in_a(in_a), .in_b(in_b), .in_c(in_c),
        .vote_out(vote_out), .disagree(disagree)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [W-1:0] model(input logic [1:0] m, input logic [W-1:0] a,
                                           input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] lo, hi;
        case (m)
            2'b01: return (a & b) | (b & c) | (c & a);
            2'b10: begin
                lo = (a < b) ? a : b;
                hi = (a < b) ? b : a;
                if (c <= lo) return lo;
                if (c >= hi) return hi;
                return c;
            end
            default: return (a == b) ? a : c;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: applies inputs at a falling edge and queues the expected result.
    task automatic drive(input logic [1:0] m, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] c, input string tag);
        item_t it;
        @(negedge clk);
        mode = m; in_a = a; in_b = b; in_c = c;
        it.mode = m; it.a = a; it.b = b; it.c = c;
        it.exp = model(m, a, b, c);
        it.dis = (a != b);
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor: each queued item is registered at the next rising edge (R7).
    always @(posedge clk) begin
        if (!rst && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            #2;
            check({it.tag, " R7 word"}, vote_out, it.exp);
            check({it.tag, " R6 disagree"}, {{(W-1){1'b0}}, disagree}, {{(W-1){1'b0}}, it.dis});
            if (it.mode == 2'b00 || it.mode == 2'b11)
                check({it.tag, " R2 member"}, {{(W-1){1'b0}},
                      (vote_out == it.a) || (vote_out == it.b) || (vote_out == it.c)},
                      {{(W-1){1'b0}}, 1'b1});
        end
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] ra, rb, rc;
        // R8: reset clears outputs even with disagreeing inputs present
        in_a = 16'h1234; in_b = 16'h0F0F; in_c = 16'hFFFF;
        repeat (3) @(posedge clk);
        #2;
        check("R8 reset word", vote_out, '0);
        check("R8 reset disagree", {{(W-1){1'b0}}, disagree}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R1: agreement passes A, disagreement passes C
        drive(2'b00, 16'hA5A5, 16'hA5A5, 16'h0000, "R1 agree");
        drive(2'b00, 16'hA5A5, 16'hA5A4, 16'h7777, "R1 differ");
        // R2/R3/R4 on the three-way split 000/101/110
        drive(2'b00, 16'h0000, 16'h0005, 16'h0006, "R2 three-way");
        drive(2'b01, 16'h0000, 16'h0005, 16'h0006, "R3 example");
        drive(2'b10, 16'h0000, 16'h0005, 16'h0006, "R4 example");
        // R4: repeated value wins, and extremes
        drive(2'b10, 16'hFFFF, 16'h0001, 16'h0001, "R4 duplicate");
        drive(2'b10, 16'hFFFF, 16'h0000, 16'h8000, "R4 extremes");
        // R5: spare code acts as word vote
        drive(2'b11, 16'h1111, 16'h2222, 16'h3333, "R5 spare differ");
        drive(2'b11, 16'h4444, 16'h4444, 16'h3333, "R5 spare agree");
        // R6: flag in non-word modes
        drive(2'b01, 16'hF0F0, 16'hF0F0, 16'h0F0F, "R6 bitwise agree");
        drive(2'b10, 16'h0001, 16'h0002, 16'h0003, "R6 median differ");

        for (int n = 0; n < 400; n++) begin
            ra = 16'($urandom);
            rb = ($urandom % 2 == 0) ? ra : 16'($urandom);
            rc = ($urandom % 4 == 0) ? ra : 16'($urandom);
            drive(2'($urandom), ra, rb, rc, "R1 R3 R4 random");
        end

        @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule